// File: doc/BRIEF.md
# Thermal Duty-Cycle Stall Controller

This block holds a processor's temperature near a target. It does not stop the whole clock when the chip runs hot. Instead it stalls only the domains that are overheated, for a fraction of their cycles. Each time the sensor front end presents a fresh set of per-domain temperatures, the block does the following:

- finds the hottest reading;
- subtracts the programmable setpoint from it;
- multiplies the difference by a programmable gain;
- adds the product into a saturating accumulator.

The upper bits of the accumulator form a duty code. That code selects a stall pattern in which a stressed domain runs for several cycles and then stalls for exactly one.

A domain counts as stressed when its own reading in the latest sample is at or above a trigger threshold. Only stressed domains see their enable drop. Every other domain keeps its enable high. The arithmetic is done over several cycles by a small sequencer, one multiplier and one adder, because the thermal loop is slow and a fast response is not needed.

Top module: `thermal_toggle_ctrl`

## Requirements
- R1: After reset, `en_o` is all ones and `duty_o` is 0.
- R2: The control error for a sample is computed from the largest of the four domain readings. Domain d's reading is `temp_i[8*d+7:8*d]`. The error is that largest reading minus `setpoint_i`, whichever domain holds it.
- R3: Each accepted sample adds (max − setpoint) × `gain_i` to an accumulator that is 5 bits wide. The duty code is accumulator bits [4:2]. `duty_o` shows this code once it has been applied.
- R4: The accumulator saturates at 31 and at 0 and never wraps.
- R5: The multiplier uses the `gain_i` value captured with the sample. A gain of 1 moves the accumulator by the bare error, and a gain of 3 moves it by three times the error.
- R6: With an applied code c in 1..7, a stressed domain's enable repeats a period of 9−c cycles: 8−c cycles high, then one cycle low. With code 0 no stall occurs.
- R7: A domain whose reading in the latest sample is below `trigger_i` keeps its enable high continuously, whatever the duty code is.
- R8: A newly computed code replaces a nonzero applied code only on the cycle that follows a stall cycle, which is the end of a period.
- R9: All stressed domains stall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | One-cycle strobe: new temperatures valid (ignored while a sample is being processed) |
| temp_i | input | 32 | Four 8-bit unsigned readings, domain d in bits [8d+7:8d] |
| setpoint_i | input | 8 | Target temperature |
| trigger_i | input | 8 | Stress threshold for each domain |
| gain_i | input | 4 | Controller gain |
| en_o | output | 4 | Per-domain run enable, 1 = run |
| duty_o | output | 3 | Duty code currently applied |

## Verification
Some internal faults appear at the ports soon after a sample:

- A wrong hottest-reading scan, error sign or gain product leaves a wrong `duty_o` within about fifteen cycles of the strobe, once the next period boundary is reached.
- A wrong saturation shows as a code that wraps to a small value after a large step.

Other faults appear in the enable pattern within one period of at most eight cycles:

- A wrong period counter shows as a stall gap of the wrong length.
- A wrong stress latch lowers the enable of a cool domain or never lowers a hot one.
- A code applied in the middle of a period shows as a change in `duty_o` that is not preceded by a stall.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_MUL,
    ST_ACC
  } pi_state_e;
endpackage

// File: rtl/ttc_pi_core.sv
module ttc_pi_core
  import ttc_pkg::*;
#(
  parameter int NUM_DOM = 4,
  parameter int TEMP_W  = 8,
  parameter int GAIN_W  = 4,
  parameter int CODE_W  = 3,
  parameter int FRAC_W  = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sample_i,
  input  logic [NUM_DOM*TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0]         setpoint_i,
  input  logic [TEMP_W-1:0]         trigger_i,
  input  logic [GAIN_W-1:0]         gain_i,
  output logic [CODE_W-1:0]         code_o,
  output logic [NUM_DOM-1:0]        stress_o
);
  localparam int ACC_W = CODE_W + FRAC_W;
  localparam int EW    = TEMP_W + 1;
  localparam int PW    = EW + GAIN_W + 1;
  localparam int SW    = PW + ACC_W + 1;
  localparam int IDX_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;
  localparam logic [SW-1:0] SUM_CAP = {{(SW-ACC_W){1'b0}}, {ACC_W{1'b1}}};
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_DOM - 1);

  pi_state_e           state_q;
  logic [TEMP_W-1:0]   tmp_q [NUM_DOM];
  logic [TEMP_W-1:0]   sp_q, max_q;
  logic [GAIN_W-1:0]   gain_q;
  logic [IDX_W-1:0]    idx_q;
  logic [PW-1:0]       prod_q;
  logic [ACC_W-1:0]    acc_q;
  logic [NUM_DOM-1:0]  stress_q, stress_nx;

  logic [EW-1:0] err_w;
  logic [PW-1:0] err_x, gain_x;
  logic [SW-1:0] sum_w;
  logic [ACC_W-1:0] acc_nx;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_stress
    assign stress_nx[d] = temp_i[d*TEMP_W +: TEMP_W] >= trigger_i;
  end

  assign err_w  = {1'b0, max_q} - {1'b0, sp_q};
  assign err_x  = {{(PW-EW){err_w[EW-1]}}, err_w};
  assign gain_x = {{(PW-GAIN_W){1'b0}}, gain_q};
  assign sum_w  = {{(SW-ACC_W){1'b0}}, acc_q} + {{(SW-PW){prod_q[PW-1]}}, prod_q};

  // clamp to [0, 2^ACC_W-1]
  always_comb begin
    if (sum_w[SW-1])          acc_nx = '0;
    else if (sum_w > SUM_CAP) acc_nx = '1;
    else                      acc_nx = sum_w[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      for (int d = 0; d < NUM_DOM; d++) tmp_q[d] <= '0;
      sp_q     <= '0;
      max_q    <= '0;
      gain_q   <= '0;
      idx_q    <= '0;
      prod_q   <= '0;
      acc_q    <= '0;
      stress_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (sample_i) begin
          for (int d = 0; d < NUM_DOM; d++) tmp_q[d] <= temp_i[d*TEMP_W +: TEMP_W];
          sp_q     <= setpoint_i;
          gain_q   <= gain_i;
          stress_q <= stress_nx;
          max_q    <= '0;
          idx_q    <= '0;
          state_q  <= ST_SCAN;
        end
        ST_SCAN: begin
          if (tmp_q[idx_q] > max_q) max_q <= tmp_q[idx_q];
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_LAST) state_q <= ST_MUL;
        end
        ST_MUL: begin
          prod_q  <= err_x * gain_x;
          state_q <= ST_ACC;
        end
        ST_ACC: begin
          acc_q   <= acc_nx;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign code_o   = acc_q[ACC_W-1:FRAC_W];
  assign stress_o = stress_q;
endmodule

// File: rtl/ttc_duty_timer.sv
module ttc_duty_timer #(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] act_o,
  output logic              stall_o
);
  localparam int LEVELS = 1 << CODE_W;
  localparam int CNT_W  = $clog2(LEVELS + 1);

  logic [CODE_W-1:0] act_q;
  logic [CNT_W-1:0]  cnt_q, last_w;
  logic              at_end;

  // period = LEVELS+1-code, last count = LEVELS-code
  assign last_w = CNT_W'(LEVELS) - CNT_W'(act_q);
  assign at_end = (act_q != '0) && (cnt_q == last_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      cnt_q <= '0;
    end else if (act_q == '0 || at_end) begin
      act_q <= code_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign act_o   = act_q;
  assign stall_o = at_end;
endmodule

// File: rtl/ttc_dom_gate.sv
module ttc_dom_gate (
  input  logic stall_i,
  input  logic stress_i,
  output logic en_o
);
  assign en_o = ~(stall_i & stress_i);
endmodule

// File: rtl/thermal_toggle_ctrl.sv
module thermal_toggle_ctrl #(
  parameter int NUM_DOM = 4,
  parameter int TEMP_W  = 8,
  parameter int GAIN_W  = 4,
  parameter int CODE_W  = 3,
  parameter int FRAC_W  = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sample_i,
  input  logic [NUM_DOM*TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0]         setpoint_i,
  input  logic [TEMP_W-1:0]         trigger_i,
  input  logic [GAIN_W-1:0]         gain_i,
  output logic [NUM_DOM-1:0]        en_o,
  output logic [CODE_W-1:0]         duty_o
);
  logic [CODE_W-1:0]  code_w;
  logic [NUM_DOM-1:0] stress_w;
  logic               stall_w;

  ttc_pi_core #(
    .NUM_DOM(NUM_DOM), .TEMP_W(TEMP_W), .GAIN_W(GAIN_W),
    .CODE_W(CODE_W), .FRAC_W(FRAC_W)
  ) u_core (
    .clk_i, .rst_ni, .sample_i, .temp_i, .setpoint_i, .trigger_i, .gain_i,
    .code_o(code_w), .stress_o(stress_w)
  );

  ttc_duty_timer #(.CODE_W(CODE_W)) u_timer (
    .clk_i, .rst_ni, .code_i(code_w), .act_o(duty_o), .stall_o(stall_w)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_gate
    ttc_dom_gate u_gate (.stall_i(stall_w), .stress_i(stress_w[d]), .en_o(en_o[d]));
  end
endmodule

// File: rtl/ttc_checker.sv
module ttc_checker #(
  parameter int NUM_DOM = 4,
  parameter int CODE_W  = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_DOM-1:0] en_o,
  input logic [CODE_W-1:0]  duty_o,
  input logic               stall_i,
  input logic [NUM_DOM-1:0] stress_i
);
  // R8
  code_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(duty_o) |-> ($past(duty_o) == '0 || $past(stall_i)));

  // R6
  single_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> !stall_i);

  // R7
  cool_domain_runs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~en_o) & (~stress_i)) == '0);

  // R6
  zero_code_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_o == '0) |-> (en_o == '1));

  // R9
  stall_together_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o != '1) |-> $countones(~en_o) == $countones(stress_i));
endmodule

bind thermal_toggle_ctrl ttc_checker #(.NUM_DOM(NUM_DOM), .CODE_W(CODE_W)) u_chk (
  .clk_i, .rst_ni, .en_o, .duty_o, .stall_i(stall_w), .stress_i(stress_w)
);

// File: tb/thermal_toggle_ctrl_tb.sv
`timescale 1ns/1ps
module thermal_toggle_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample = 1'b0;
  logic [31:0] temp = '0;
  logic [7:0]  setpoint = '0, trigger = '0;
  logic [3:0]  gain = '0;
  logic [3:0]  en;
  logic [2:0]  duty;

  int checks = 0, errors = 0, cyc = 0;
  int acc_m = 0;
  logic [3:0] exp_stress = '0;

  always #2 clk = ~clk;

  thermal_toggle_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .temp_i(temp),
    .setpoint_i(setpoint), .trigger_i(trigger), .gain_i(gain),
    .en_o(en), .duty_o(duty)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp<=%0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_sample(input logic [7:0] t0, t1, t2, t3,
                           input logic [7:0] sp, trg, input logic [3:0] g, input string req);
    int mx;
    logic [2:0] prev_d;
    logic [3:0] prev_e;
    mx = t0;
    if (t1 > mx) mx = t1;
    if (t2 > mx) mx = t2;
    if (t3 > mx) mx = t3;
    acc_m = acc_m + (mx - int'(sp)) * int'(g);
    if (acc_m < 0) acc_m = 0;
    if (acc_m > 31) acc_m = 31;
    exp_stress = {t3 >= trg, t2 >= trg, t1 >= trg, t0 >= trg};
    @(negedge clk);
    temp = {t3, t2, t1, t0}; setpoint = sp; trigger = trg; gain = g; sample = 1'b1;
    @(negedge clk);
    sample = 1'b0;
    prev_d = duty; prev_e = en;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (duty != prev_d && prev_d != 0 && exp_stress != 0)
        check(prev_e != 4'hF, "R8 code change after stall", int'(prev_e), 0);
      prev_d = duty; prev_e = en;
    end
    check(duty == 3'(acc_m >> 2), req, int'(duty), acc_m >> 2);
  endtask

  task automatic check_pattern(input string req);
    int c, gap;
    bit bad;
    c = acc_m >> 2;
    if (c == 0 || exp_stress == 0) begin
      bad = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (en != 4'hF) bad = 1;
      end
      check(!bad, req, int'(bad), 0);
    end else begin
      gap = 0;
      while (en == 4'hF && gap < 20) begin @(negedge clk); gap++; end
      check(~en == exp_stress, {req, " R9 stall mask"}, int'(~en), int'(exp_stress));
      gap = 0;
      do begin @(negedge clk); gap++; end while (en == 4'hF && gap < 20);
      check(gap == 9 - c, {req, " R6 period"}, gap, 9 - c);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(en == 4'hF, "R1 enables", int'(en), 15);
    check(duty == 0, "R1 duty", int'(duty), 0);
  endtask

  task automatic t_track();
    do_sample(8'd90, 8'd95, 8'd102, 8'd80, 8'd100, 8'd100, 4'd3, "R3 step 1");
    check_pattern("R6 code1");
    do_sample(8'd90, 8'd95, 8'd102, 8'd80, 8'd100, 8'd100, 4'd3, "R3 step 2");
    check_pattern("R6 code3");
  endtask

  task automatic t_saturate();
    do_sample(8'd120, 8'd60, 8'd60, 8'd60, 8'd100, 8'd100, 4'd3, "R2 R4 upper sat");
    check_pattern("R6 code7");
    do_sample(8'd50, 8'd50, 8'd50, 8'd50, 8'd100, 8'd100, 4'd3, "R4 lower sat");
    check_pattern("R6 code0");
  endtask

  task automatic t_gain_one();
    do_sample(8'd101, 8'd101, 8'd99, 8'd0, 8'd100, 8'd101, 4'd1, "R5 gain1 s1");
    do_sample(8'd101, 8'd101, 8'd99, 8'd0, 8'd100, 8'd101, 4'd1, "R5 gain1 s2");
    do_sample(8'd101, 8'd101, 8'd99, 8'd0, 8'd100, 8'd101, 4'd1, "R5 gain1 s3");
    do_sample(8'd101, 8'd101, 8'd99, 8'd0, 8'd100, 8'd101, 4'd1, "R5 gain1 s4");
    check_pattern("R7 two stressed");
  endtask

  task automatic t_cool_domains();
    do_sample(8'd99, 8'd99, 8'd99, 8'd99, 8'd90, 8'd200, 4'd3, "R7 code7 no stress");
    check_pattern("R7 all below trigger");
  endtask

  task automatic t_all_stressed();
    do_sample(8'd80, 8'd80, 8'd80, 8'd80, 8'd90, 8'd70, 4'd1, "R3 down step");
    check_pattern("R9 all stressed");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_track();
    t_saturate();
    t_gain_one();
    t_cool_domains();
    t_all_stressed();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule